// File: doc/BRIEF.md
# Programmable I/O Port Mode Cell

This block is one configurable port cell placed between a group of external pin signals and the matching lines of an internal switch matrix. A stored mode decides how the two sides are joined. Data can flow pin-to-matrix, either straight through or via a capture flop. It can flow matrix-to-pin, again straight or via a flop. Either side can instead be held at a constant, or the two sides can be fully isolated. The pin is modelled as three separate signals: an input value, an output value and an active-low drive enable. There is no tristate wire.

The mode is loaded from a 4-bit code on a write strobe, synchronous to the configuration clock. A reset parks the cell disconnected. Two further clocks serve the data path: one clocks the pin-side capture flops and the other clocks the matrix-side capture flops. These flops have no reset, so their contents survive a device reset. A global active-low output enable can always silence the pin driver. The `WIDTH` parameter sets how many lanes share one mode register.

Top module: `iocell_port`

## Requirements
- R1: While `rst_n` is low, the mode is disconnected. In that mode `mtx_vld` is 0, `mtx_o` is 0, every bit of `pin_oe_n` is 1 and `pin_o` is 0.
- R2: With mode code 1 (plain input), `mtx_o` follows `pin_i` combinationally and `mtx_vld` is 1.
- R3: With mode code 2 (registered input), `mtx_o` shows the `pin_i` value sampled at the latest rising edge of `in_clk`, and `mtx_vld` is 1.
- R4: With mode code 3 (plain output) and `oe_n` low, `pin_o` follows `mtx_i` combinationally and `pin_oe_n` is all 0.
- R5: With mode code 4 (registered output) and `oe_n` low, `pin_o` shows the `mtx_i` value sampled at the latest rising edge of `out_clk`, and `pin_oe_n` is all 0.
- R6: Reset neither clears nor alters the two capture flops. After reset, re-entering mode 2 or mode 4 shows the values captured before reset, with no further edge on `in_clk` or `out_clk`.
- R7: With mode code 5 and `oe_n` low, the pin is driven all 0. With mode code 6 and `oe_n` low, the pin is driven all 1. In both cases the value of `mtx_i` has no effect.
- R8: Mode code 7 drives `mtx_o` to all 0 and mode code 8 drives it to all 1, with `mtx_vld` at 1. In both cases the value of `pin_i` has no effect.
- R9: Whenever `oe_n` is high, every bit of `pin_oe_n` is 1 and `pin_o` is 0, in every mode.
- R10: Modes 0, 3, 4, 5 and 6 hold `mtx_vld` at 0 and `mtx_o` at 0. Modes 0, 1, 2, 7 and 8 hold `pin_oe_n` at all 1 and `pin_o` at 0. Code 0 is the disconnected mode.
- R11: A rising edge of `clk` with `cfg_we` high loads `cfg_mode`. A code from 9 to 15 loads the disconnected mode. With `cfg_we` low, the mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock for the mode register |
| rst_n | input | 1 | Asynchronous active-low reset; parks the cell disconnected |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 4 | Mode code to load |
| in_clk | input | 1 | Clock of the pin-side capture flops |
| out_clk | input | 1 | Clock of the matrix-side capture flops |
| oe_n | input | 1 | Global active-low output enable |
| pin_i | input | WIDTH | Value present on the external pins |
| pin_o | output | WIDTH | Value driven towards the pins (0 when not driving) |
| pin_oe_n | output | WIDTH | Active-low pin drive enable per lane |
| mtx_i | input | WIDTH | Value of the switch-matrix lines |
| mtx_o | output | WIDTH | Value the cell drives onto the matrix lines |
| mtx_vld | output | 1 | High when `mtx_o` carries a driven value |

## Verification
The registered-mode properties assume that `pin_i` and `mtx_i` hold known values at every edge of `in_clk` and `out_clk`. They also assume that the mode does not change between two such edges without the check noticing. The bench therefore drives known data from time zero. It changes the mode only on `clk`, and it pulses the two data clocks briefly while the inputs are stable. The reset check assumes reset is held across at least one `clk` falling edge, which every reset in the bench does. The bench clocks known data into both capture flops before it checks any registered output, because those flops start unknown.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

   localparam int unsigned MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      PM_NONE    = 4'd0,
      PM_IN      = 4'd1,
      PM_IN_REG  = 4'd2,
      PM_OUT     = 4'd3,
      PM_OUT_REG = 4'd4,
      PM_PIN_LO  = 4'd5,
      PM_PIN_HI  = 4'd6,
      PM_MTX_LO  = 4'd7,
      PM_MTX_HI  = 4'd8
   } port_mode_e;

   // Unused codes collapse to the disconnected mode (R11)
   function automatic port_mode_e decode_mode(input logic [MODE_W-1:0] code);
      case (code)
         4'd1:    return PM_IN;
         4'd2:    return PM_IN_REG;
         4'd3:    return PM_OUT;
         4'd4:    return PM_OUT_REG;
         4'd5:    return PM_PIN_LO;
         4'd6:    return PM_PIN_HI;
         4'd7:    return PM_MTX_LO;
         4'd8:    return PM_MTX_HI;
         default: return PM_NONE;
      endcase
   endfunction

endpackage

// File: rtl/iocell_mode_reg.sv
module iocell_mode_reg
   import iocell_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [MODE_W-1:0] cfg_mode,
   output port_mode_e        mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= PM_NONE;
      else if (cfg_we)
         mode_q <= decode_mode(cfg_mode);
   end

   // R11: no strobe, no change
   a_r11_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> mode_q == $past(mode_q));

   // R11: codes above 8 park the cell
   a_r11_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_mode > 4'd8) |=> mode_q == PM_NONE);

endmodule

// File: rtl/iocell_in_path.sv
module iocell_in_path
   import iocell_pkg::*;
#(
   parameter int unsigned WIDTH = 2
) (
   input  logic             in_clk,
   input  logic             rst_n,
   input  port_mode_e       mode,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] mtx_o,
   output logic             mtx_vld
);

   logic [WIDTH-1:0] cap_q;

   // Capture flops: no reset by design (R6)
   for (genvar g = 0; g < WIDTH; g++) begin : g_lane
      always_ff @(posedge in_clk) begin
         cap_q[g] <= pin_i[g];
      end
   end

   always_comb begin
      mtx_o   = '0;
      mtx_vld = 1'b0;
      case (mode)
         PM_IN: begin
            mtx_o   = pin_i;
            mtx_vld = 1'b1;
         end
         PM_IN_REG: begin
            mtx_o   = cap_q;
            mtx_vld = 1'b1;
         end
         PM_MTX_LO: begin
            mtx_o   = '0;
            mtx_vld = 1'b1;
         end
         PM_MTX_HI: begin
            mtx_o   = '1;
            mtx_vld = 1'b1;
         end
         default: begin
            mtx_o   = '0;
            mtx_vld = 1'b0;
         end
      endcase
   end

   a_r2_plain_in: assert property (@(posedge in_clk) disable iff (!rst_n)
      mode == PM_IN |-> (mtx_o == pin_i && mtx_vld));

   a_r3_reg_in: assert property (@(posedge in_clk) disable iff (!rst_n)
      mode == PM_IN_REG |=> (mode != PM_IN_REG || mtx_o == $past(pin_i)));

   a_r8_array_force: assert property (@(posedge in_clk) disable iff (!rst_n)
      mode == PM_MTX_HI |-> (&mtx_o && mtx_vld));

   a_r10_quiet_matrix: assert property (@(posedge in_clk) disable iff (!rst_n)
      !mtx_vld |-> mtx_o == '0);

endmodule

// File: rtl/iocell_out_path.sv
module iocell_out_path
   import iocell_pkg::*;
#(
   parameter int unsigned WIDTH = 2
) (
   input  logic             out_clk,
   input  logic             rst_n,
   input  port_mode_e       mode,
   input  logic             oe_n,
   input  logic [WIDTH-1:0] mtx_i,
   output logic [WIDTH-1:0] pin_o,
   output logic [WIDTH-1:0] pin_oe_n
);

   logic [WIDTH-1:0] hold_q;
   logic [WIDTH-1:0] sel;
   logic             mode_drives;
   logic             drive_en;

   // Capture flops: no reset by design (R6)
   for (genvar g = 0; g < WIDTH; g++) begin : g_lane
      always_ff @(posedge out_clk) begin
         hold_q[g] <= mtx_i[g];
      end
   end

   always_comb begin
      sel         = '0;
      mode_drives = 1'b1;
      case (mode)
         PM_OUT:     sel = mtx_i;
         PM_OUT_REG: sel = hold_q;
         PM_PIN_LO:  sel = '0;
         PM_PIN_HI:  sel = '1;
         default: begin
            sel         = '0;
            mode_drives = 1'b0;
         end
      endcase
   end

   assign drive_en = mode_drives & ~oe_n;
   assign pin_oe_n = {WIDTH{~drive_en}};
   assign pin_o    = drive_en ? sel : '0;

   a_r4_plain_out: assert property (@(posedge out_clk) disable iff (!rst_n)
      (mode == PM_OUT && !oe_n) |-> (pin_o == mtx_i && pin_oe_n == '0));

   a_r5_reg_out: assert property (@(posedge out_clk) disable iff (!rst_n)
      (mode == PM_OUT_REG && !oe_n) |=>
         (mode != PM_OUT_REG || oe_n || pin_o == $past(mtx_i)));

   a_r7_pin_force: assert property (@(posedge out_clk) disable iff (!rst_n)
      (mode == PM_PIN_HI && !oe_n) |-> (&pin_o && pin_oe_n == '0));

   a_r9_oe_gate: assert property (@(posedge out_clk) disable iff (!rst_n)
      oe_n |-> (&pin_oe_n && pin_o == '0));

   a_r10_quiet_pin: assert property (@(posedge out_clk) disable iff (!rst_n)
      pin_oe_n[0] |-> pin_o == '0);

endmodule

// File: rtl/iocell_port.sv
module iocell_port
   import iocell_pkg::*;
#(
   parameter int unsigned WIDTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [MODE_W-1:0] cfg_mode,
   input  logic              in_clk,
   input  logic              out_clk,
   input  logic              oe_n,
   input  logic [WIDTH-1:0]  pin_i,
   output logic [WIDTH-1:0]  pin_o,
   output logic [WIDTH-1:0]  pin_oe_n,
   input  logic [WIDTH-1:0]  mtx_i,
   output logic [WIDTH-1:0]  mtx_o,
   output logic              mtx_vld
);

   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("iocell_port: WIDTH must lie in 1..64");
   end

   port_mode_e mode_q;

   iocell_mode_reg i_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_mode (cfg_mode),
      .mode_q   (mode_q)
   );

   iocell_in_path #(.WIDTH(WIDTH)) i_in (
      .in_clk  (in_clk),
      .rst_n   (rst_n),
      .mode    (mode_q),
      .pin_i   (pin_i),
      .mtx_o   (mtx_o),
      .mtx_vld (mtx_vld)
   );

   iocell_out_path #(.WIDTH(WIDTH)) i_out (
      .out_clk  (out_clk),
      .rst_n    (rst_n),
      .mode     (mode_q),
      .oe_n     (oe_n),
      .mtx_i    (mtx_i),
      .pin_o    (pin_o),
      .pin_oe_n (pin_oe_n)
   );

   // R1: reset parks both sides
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_park: assert (!mtx_vld && mtx_o == '0 && &pin_oe_n && pin_o == '0);
      end
   end

endmodule

// File: tb/test_iocell_port.sv
`timescale 1ns/1ps
module test_iocell_port;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [3:0]   cfg_mode = 4'd0;
   logic         in_clk = 1'b0;
   logic         out_clk = 1'b0;
   logic         oe_n = 1'b0;
   logic [W-1:0] pin_i = '0;
   logic [W-1:0] pin_o;
   logic [W-1:0] pin_oe_n;
   logic [W-1:0] mtx_i = '0;
   logic [W-1:0] mtx_o;
   logic         mtx_vld;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int cur_mode = 0;
   logic [W-1:0] exp_in, exp_out;

   iocell_port #(.WIDTH(W)) i_iocell_port (.*);

   always #4 clk = ~clk;

   task automatic report;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not complete");
         report();
      end
   end

   task automatic pulse_in;
      #1 in_clk = 1'b1; exp_in = pin_i;
      #1 in_clk = 1'b0;
   endtask

   task automatic pulse_out;
      #1 out_clk = 1'b1; exp_out = mtx_i;
      #1 out_clk = 1'b0;
   endtask

   task automatic write_mode(input int code);
      @(negedge clk);
      cfg_we = 1'b1; cfg_mode = 4'(code);
      @(negedge clk);
      cfg_we = 1'b0;
      cur_mode = (code > 8) ? 0 : code;
   endtask

   function automatic string tag_of(input int m, input logic oe);
      if (oe && m inside {3, 4, 5, 6}) return "R9";
      case (m)
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5, 6: return "R7";
         7, 8: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic check_all(input string tag);
      logic [W-1:0] em, ep, eoe;
      logic ev, drv;
      #1;
      em = '0; ev = 1'b0; ep = '0;
      case (cur_mode)
         1: begin em = pin_i; ev = 1'b1; end
         2: begin em = exp_in; ev = 1'b1; end
         7: ev = 1'b1;
         8: begin em = '1; ev = 1'b1; end
         default: ;
      endcase
      drv = (cur_mode inside {3, 4, 5, 6}) && !oe_n;
      if (drv) begin
         case (cur_mode)
            3: ep = mtx_i;
            4: ep = exp_out;
            6: ep = '1;
            default: ep = '0;
         endcase
      end
      eoe = drv ? '0 : '1;
      checks++;
      if ({mtx_vld, mtx_o, pin_oe_n, pin_o} !== {ev, em, eoe, ep}) begin
         fails++;
         $display("FAIL %s mode=%0d oe_n=%b: got vld=%b mtx=%h oe_n=%h pin=%h, expected vld=%b mtx=%h oe_n=%h pin=%h",
                  tag, cur_mode, oe_n, mtx_vld, mtx_o, pin_oe_n, pin_o, ev, em, eoe, ep);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      pin_i = 4'h5; mtx_i = 4'hA;
      repeat (3) @(negedge clk);
      cur_mode = 0;
      check_all("R1");
      // initialise the reset-less capture flops before any registered check
      pulse_in(); pulse_out();
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R10");

      // directed: each mode once
      write_mode(1); pin_i = 4'h9; check_all("R2");
      pin_i = 4'h6; check_all("R2");
      write_mode(2); pin_i = 4'hC; check_all("R3");
      pulse_in(); pin_i = 4'h3; check_all("R3");
      write_mode(3); mtx_i = 4'h7; check_all("R4");
      write_mode(4); mtx_i = 4'hE; pulse_out(); mtx_i = 4'h1; check_all("R5");
      write_mode(5); mtx_i = 4'hF; check_all("R7");
      write_mode(6); mtx_i = 4'h0; check_all("R7");
      write_mode(7); pin_i = 4'hF; check_all("R8");
      write_mode(8); pin_i = 4'h0; check_all("R8");
      oe_n = 1'b1;
      write_mode(3); check_all("R9");
      write_mode(6); check_all("R9");
      oe_n = 1'b0;

      // R11: unused codes and strobe low
      write_mode(12); check_all("R11");
      write_mode(15); check_all("R11");
      write_mode(3);
      @(negedge clk); cfg_mode = 4'd8; cfg_we = 1'b0;
      @(negedge clk); check_all("R11");

      // R6: capture values survive reset
      write_mode(2); pin_i = 4'hB; pulse_in();
      mtx_i = 4'hD; pulse_out();
      pin_i = 4'h2; mtx_i = 4'h4;
      #2 rst_n = 1'b0;
      cur_mode = 0;
      check_all("R1");
      repeat (2) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      write_mode(2); check_all("R6");
      write_mode(4); check_all("R6");

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         int code;
         code = $urandom_range(0, 15);
         write_mode(code);
         pin_i = W'($urandom);
         mtx_i = W'($urandom);
         oe_n  = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 1) == 1) pulse_in();
         if ($urandom_range(0, 1) == 1) pulse_out();
         if ($urandom_range(0, 2) == 0) begin
            pin_i = W'($urandom);
            mtx_i = W'($urandom);
         end
         check_all(code > 8 ? "R11" : tag_of(cur_mode, oe_n));
      end

      done = 1;
      report();
   end

endmodule